// File: doc/BRIEF.md
# Dual H-Bridge Gate Command Decoder

This block converts logic-level commands into gate-enable signals for a set of H-bridges. The default build has two bridges. Each bridge is made of two half-bridges, and each half-bridge has one high-side and one low-side gate enable. Every bridge takes two command bits. Each bit is taken either from an external pin, which is synchronized first, or from a register-driven control bit. The source is chosen separately for each bit, so a bridge can be steered from software while its pins stay idle.

A two-bit mode field selects the decode for each bridge. The phase/enable scheme uses one bit as a speed (enable) command and the other as a direction (phase) command. The dual-PWM scheme treats the two bits as independent drive levels and gives four output states. A freewheel select bit per bridge chooses whether active freewheeling closes both low-side switches or both high-side switches. A Hi-Z bit per bridge overrides everything else for that bridge.

The gate outputs are registered. A per-half-bridge guard enforces a programmable dead time before a gate turns on. A single global disable input drops all gates at the next clock edge.

Top module: `hbd_gate_decoder`

## Requirements
- R1: In mode 01b, when the enable bit (command bit 2b of bridge b) is 0, the phase bit is ignored and the bridge freewheels. With the freewheel select at 0 (the reset value of that select), both low-side gates are on. With the select at 1, both high-side gates are on.
- R2: In mode 01b with the enable bit at 1, a phase bit (command bit 2b+1) of 1 drives forward: high gate of the first half-bridge and low gate of the second half-bridge on. A phase bit of 0 drives reverse: low gate of the first half-bridge and high gate of the second half-bridge on.
- R3: In mode 10b, command bits {bit 2b, bit 2b+1} decode as follows: 00 turns all four gates off (coast), 01 drives reverse, 10 drives forward, and 11 freewheels on the side chosen by the freewheel select.
- R4: When a bridge's Hi-Z bit is 1, all four of its gates are low, whatever its mode, commands and freewheel select.
- R5: Mode values 00b and 11b disable the bridge, with all four gates low.
- R6: A source select bit of 1 takes that command bit from the register input, and 0 takes it from the pin input. The unselected source has no effect on the gates.
- R7: The high and low gates of one half-bridge are never both high. When a half-bridge changes from one gate to the other, both gates stay low for exactly D+1 cycles, where D is the dead-time input (0 to 255).
- R8: When the global disable input is high at a clock edge, all gate outputs are low after that edge.
- R9: A pin command reaches the gates after three clock edges: two synchronizer stages and the output register. A register command reaches the gates after one edge.
- R10: During and after reset, all gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| global_off | input | 1 | Forces every gate low at the next edge |
| pin_cmd | input | 2*NUM_BRIDGES | Asynchronous pin commands; bit 2b is enable/first input and bit 2b+1 is phase/second input of bridge b |
| reg_cmd | input | 2*NUM_BRIDGES | Register-driven commands, same bit layout |
| src_sel | input | 2*NUM_BRIDGES | Per-bit source: 1 selects register, 0 selects pin |
| bridge_mode | input | 2*NUM_BRIDGES | Two mode bits per bridge: 01b phase/enable, 10b dual PWM, others off |
| fw_high | input | NUM_BRIDGES | Freewheel side per bridge: 0 low-side, 1 high-side |
| hiz | input | NUM_BRIDGES | Per-bridge high-impedance override |
| dead_cycles | input | DT_W | Dead-time setting D |
| gate_hi | output | 2*NUM_BRIDGES | High-side gate enable per half-bridge |
| gate_lo | output | 2*NUM_BRIDGES | Low-side gate enable per half-bridge |

## Verification
A sweep covers every combination of mode, command pair, freewheel select, Hi-Z and source for one bridge. The other bridge receives the complementary settings at the same time, and the unselected source always carries inverted values. This separates the two decode schemes, shows the phase bit is ignored when enable is low, shows the Hi-Z override and the disabled mode codes, and shows that the two bridges do not affect each other. Reversals at several dead-time settings measure the exact width of the both-low gap on both half-bridges. Separate runs time the pin and register paths edge by edge and check that the global disable acts at the next edge.

// File: rtl/hbd_pkg.sv
`timescale 1ns/1ps
package hbd_pkg;
   typedef enum logic [1:0] {
      BM_OFF_LO = 2'b00,
      BM_PHEN   = 2'b01,
      BM_PWM    = 2'b10,
      BM_OFF_HI = 2'b11
   } bridge_mode_e;

   // Requested state of one bridge: gate wishes per half-bridge
   typedef struct packed {
      logic [1:0] hi;
      logic [1:0] lo;
   } bridge_req_t;
endpackage

// File: rtl/hbd_sync.sv
`timescale 1ns/1ps
module hbd_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbd_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else if (s == 0) begin
            chain[s] <= d_async;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hbd_bridge_decode.sv
`timescale 1ns/1ps
module hbd_bridge_decode
   import hbd_pkg::*;
(
   input  logic [1:0]  mode,
   input  logic        cmd_a,   // enable / first PWM input
   input  logic        cmd_b,   // phase  / second PWM input
   input  logic        fw_high,
   input  logic        hiz,
   output bridge_req_t req
);
   bridge_mode_e mode_e;
   bridge_req_t  fwd_req, rev_req, fw_req;

   assign mode_e = bridge_mode_e'(mode);

   always_comb begin
      fwd_req = '{hi: 2'b01, lo: 2'b10};
      rev_req = '{hi: 2'b10, lo: 2'b01};
      fw_req  = fw_high ? '{hi: 2'b11, lo: 2'b00} : '{hi: 2'b00, lo: 2'b11};
   end

   always_comb begin
      req = '0;
      if (!hiz) begin
         unique case (mode_e)
            BM_PHEN: begin
               if (!cmd_a)     req = fw_req;
               else if (cmd_b) req = fwd_req;
               else            req = rev_req;
            end
            BM_PWM: begin
               unique case ({cmd_a, cmd_b})
                  2'b00:   req = '0;
                  2'b01:   req = rev_req;
                  2'b10:   req = fwd_req;
                  default: req = fw_req;
               endcase
            end
            default: req = '0;
         endcase
      end
   end
endmodule

// File: rtl/hbd_deadtime.sv
`timescale 1ns/1ps
module hbd_deadtime #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            force_off,
   input  logic            want_hi,
   input  logic            want_lo,
   input  logic [DT_W-1:0] dead_cycles,
   output logic            gate_hi,
   output logic            gate_lo
);
   localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

   logic            gh_q, gl_q, gh_nx, gl_nx, gap_ok;
   logic [DT_W-1:0] idle_cnt, idle_nx;

   always_comb begin
      gap_ok = (idle_cnt >= dead_cycles);
      gh_nx  = 1'b0;
      gl_nx  = 1'b0;
      if (!force_off) begin
         if (want_hi && !want_lo)      gh_nx = gh_q | (!gl_q && gap_ok);
         else if (want_lo && !want_hi) gl_nx = gl_q | (!gh_q && gap_ok);
      end
      if (gh_q || gl_q)          idle_nx = '0;
      else if (idle_cnt == CNT_MAX) idle_nx = idle_cnt;
      else                       idle_nx = idle_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gh_q     <= 1'b0;
         gl_q     <= 1'b0;
         idle_cnt <= '0;
      end else begin
         gh_q     <= gh_nx;
         gl_q     <= gl_nx;
         idle_cnt <= idle_nx;
      end
   end

   assign gate_hi = gh_q;
   assign gate_lo = gl_q;

   assert_no_shoot_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(gh_q && gl_q));
   assert_hi_after_lo_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gh_q) |-> $past(!gl_q));
   assert_lo_after_hi_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gl_q) |-> $past(!gh_q));
   assert_force_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> (!gh_q && !gl_q));
endmodule

// File: rtl/hbd_gate_decoder.sv
`timescale 1ns/1ps
module hbd_gate_decoder
   import hbd_pkg::*;
#(
   parameter int NUM_BRIDGES = 2,
   parameter int DT_W        = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NCMD       = 2 * NUM_BRIDGES,
   localparam int NHALF      = 2 * NUM_BRIDGES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             global_off,
   input  logic [NCMD-1:0]  pin_cmd,
   input  logic [NCMD-1:0]  reg_cmd,
   input  logic [NCMD-1:0]  src_sel,
   input  logic [NCMD-1:0]  bridge_mode,
   input  logic [NUM_BRIDGES-1:0] fw_high,
   input  logic [NUM_BRIDGES-1:0] hiz,
   input  logic [DT_W-1:0]  dead_cycles,
   output logic [NHALF-1:0] gate_hi,
   output logic [NHALF-1:0] gate_lo
);
   if (NUM_BRIDGES < 1) begin : g_bad_bridges
      $error("hbd_gate_decoder: NUM_BRIDGES must be at least 1");
   end
   if (DT_W < 1 || DT_W > 16) begin : g_bad_dtw
      $error("hbd_gate_decoder: DT_W must be 1..16");
   end

   logic [NCMD-1:0] pin_sync, cmd_sel;

   hbd_sync #(.WIDTH(NCMD), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(pin_cmd),
      .q_sync (pin_sync)
   );

   assign cmd_sel = (src_sel & reg_cmd) | (~src_sel & pin_sync);

   for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
      bridge_req_t req;

      hbd_bridge_decode u_dec (
         .mode   (bridge_mode[2*b +: 2]),
         .cmd_a  (cmd_sel[2*b]),
         .cmd_b  (cmd_sel[2*b+1]),
         .fw_high(fw_high[b]),
         .hiz    (hiz[b]),
         .req    (req)
      );

      for (genvar h = 0; h < 2; h++) begin : g_half
         hbd_deadtime #(.DT_W(DT_W)) u_dt (
            .clk        (clk),
            .rst_n      (rst_n),
            .force_off  (global_off),
            .want_hi    (req.hi[h]),
            .want_lo    (req.lo[h]),
            .dead_cycles(dead_cycles),
            .gate_hi    (gate_hi[2*b+h]),
            .gate_lo    (gate_lo[2*b+h])
         );
      end

      assert_hiz_gates_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
         hiz[b] |=> (gate_hi[2*b +: 2] == 2'b00 && gate_lo[2*b +: 2] == 2'b00));
      assert_off_mode_gates_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (bridge_mode[2*b] == bridge_mode[2*b+1])
            |=> (gate_hi[2*b +: 2] == 2'b00 && gate_lo[2*b +: 2] == 2'b00));
   end
endmodule

// File: tb/hbd_gate_decoder_bench.sv
`timescale 1ns/1ps
module hbd_gate_decoder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       global_off = 1'b0;
   logic [3:0] pin_cmd = '0, reg_cmd = '0, src_sel = '0, bridge_mode = '0;
   logic [1:0] fw_high = '0, hiz = '0;
   logic [7:0] dead_cycles = '0;
   logic [3:0] gate_hi, gate_lo;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   hbd_gate_decoder u_hbd_gate_decoder (
      .clk(clk), .rst_n(rst_n), .global_off(global_off),
      .pin_cmd(pin_cmd), .reg_cmd(reg_cmd), .src_sel(src_sel),
      .bridge_mode(bridge_mode), .fw_high(fw_high), .hiz(hiz),
      .dead_cycles(dead_cycles), .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   // returns {lo1, lo0, hi1, hi0} for one bridge
   function automatic logic [3:0] exp_br(input logic [1:0] m, input logic a,
                                         input logic b, input logic fw, input logic hz);
      logic [3:0] fwv;
      fwv = fw ? 4'b0011 : 4'b1100;
      if (hz || m == 2'b00 || m == 2'b11) return 4'b0000;
      if (m == 2'b01) begin
         if (!a) return fwv;
         return b ? 4'b1001 : 4'b0110;
      end
      case ({a, b})
         2'b00:   return 4'b0000;
         2'b01:   return 4'b0110;
         2'b10:   return 4'b1001;
         default: return fwv;
      endcase
   endfunction

   task automatic check(input string tag, input logic [3:0] eh, input logic [3:0] el);
      n_checks++;
      if (gate_hi !== eh || gate_lo !== el) begin
         n_fail++;
         $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, gate_hi, gate_lo, eh, el);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic gap_run(input int d, input string tag);
      int gap0, gap1;
      gap0 = 0; gap1 = 0;
      src_sel = 4'hF; bridge_mode = 4'b1010; hiz = 2'b00; fw_high = 2'b00;
      dead_cycles = 8'(d);
      reg_cmd[1:0] = 2'b01;               // forward: hi0, lo1
      tick(d + 6);
      reg_cmd[1:0] = 2'b10;               // reverse: lo0, hi1
      for (int i = 0; i < d + 10; i++) begin
         @(negedge clk);
         if (!gate_hi[0] && !gate_lo[0]) gap0++;
         if (!gate_hi[1] && !gate_lo[1]) gap1++;
      end
      n_checks++;
      if (gap0 != d + 1 || gap1 != d + 1 || !gate_lo[0] || !gate_hi[1]) begin
         n_fail++;
         $display("FAIL %s: gaps=%0d/%0d expected %0d (lo0=%b hi1=%b)",
                  tag, gap0, gap1, d + 1, gate_lo[0], gate_hi[1]);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      tick(3);
      check("R10 in reset", 4'h0, 4'h0);
      rst_n = 1'b1;
      tick(2);
      check("R10 after reset", 4'h0, 4'h0);

      // Sweep: bridge A through all settings, bridge B complementary
      dead_cycles = 8'd3;
      for (int v = 0; v < 128; v++) begin
         logic [1:0] ma, mb, ina, inb;
         logic       fa, fb, ha, hb, sa, sb;
         logic [3:0] ea, eb, cmd;
         string      tag;
         ma = v[1:0]; ina = v[3:2]; fa = v[4]; ha = v[5]; sa = v[6];
         mb = ~ma; inb = ~ina; fb = ~fa; hb = ha & fa; sb = ~sa;
         cmd = {inb[0], inb[1], ina[0], ina[1]};   // bit 2b = first input
         src_sel     = {sb, sb, sa, sa};
         reg_cmd     = (src_sel & cmd) | (~src_sel & ~cmd);
         pin_cmd     = (~src_sel & cmd) | (src_sel & ~cmd);
         bridge_mode = {mb, ma};
         fw_high     = {fb, fa};
         hiz         = {hb, ha};
         tick(12);
         ea = exp_br(ma, ina[1], ina[0], fa, ha);
         eb = exp_br(mb, inb[1], inb[0], fb, hb);
         if (ha)                tag = "R4";
         else if (ma == 2'b01)  tag = ina[1] ? "R2" : "R1";
         else if (ma == 2'b10)  tag = "R3";
         else                   tag = "R5";
         tag = $sformatf("%s/R6 v=%0d", tag, v);
         check(tag, {eb[1:0], ea[1:0]}, {eb[3:2], ea[3:2]});
      end

      // R7: dead-time gap widths
      gap_run(0, "R7 D=0");
      gap_run(5, "R7 D=5");
      gap_run(2, "R7 D=2");

      // R8: global disable acts at the next edge
      reg_cmd = 4'b0101; bridge_mode = 4'b1010; dead_cycles = 8'd0;
      tick(6);
      check("R8 before disable", 4'b0101, 4'b1010);
      global_off = 1'b1;
      tick(1);
      check("R8 one edge after disable", 4'h0, 4'h0);
      global_off = 1'b0;
      tick(4);
      check("R8 after release", 4'b0101, 4'b1010);

      // R9: pin path latency three edges, register path one edge
      src_sel = 4'h0; pin_cmd = 4'h0; tick(8);
      check("R9 coast from pins", 4'h0, 4'h0);
      pin_cmd = 4'b0001;                  // bridge A forward
      tick(2);
      check("R9 pin after two edges", 4'h0, 4'h0);
      tick(1);
      check("R9 pin after three edges", 4'b0001, 4'b0010);
      src_sel = 4'h3; reg_cmd = 4'h0; tick(6);
      reg_cmd = 4'b0001;
      tick(1);
      check("R9 register after one edge", 4'b0001, 4'b0010);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule